// File: doc/BRIEF.md
# Single-Instruction Constant Selector

This block decides whether a 64-bit constant can be produced by one constant-generating instruction. It also chooses that instruction. The constant arrives with a width flag that selects a 32-bit or a 64-bit destination register. The block checks four families of forms:

- adding a 12-bit immediate to the zero register;
- subtracting a 12-bit immediate from the zero register, in both a 32-bit and a 64-bit variant;
- a zero-filled 16-bit lane move;
- an inverted 16-bit lane move, in both a 32-bit and a 64-bit variant.

When a form fits, the block reports the form code, the immediate field and the left-shift amount. When no form fits, it raises a flag telling the caller to fetch the value from a literal pool instead.

A code generator or an instruction-expansion stage would use it every cycle. It presents a constant and collects the verdict one clock later. All results are registered once, with no handshake.

Top module: `csel_const_selector`

## Requirements
- R1: Form code 1 (add) is reported when the value equals k shifted left by s, with k in 0..4095 and s in {0, 12}. The immediate is k and the shift is s, with s = 0 preferred.
- R2: Form code 2 (32-bit subtract) is reported when bits [63:32] are zero and bits [31:0] equal (0 - (k << s)) mod 2^32, with k in 1..4095 and s in {0, 12}. The immediate is k and the shift is s.
- R3: Form code 3 (64-bit subtract) is reported only in 64-bit mode, when the value equals (0 - (k << s)) mod 2^64, with k in 1..4095 and s in {0, 12}. The immediate is k and the shift is s.
- R4: Form code 4 (zero-fill move) is reported when at most one 16-bit lane at shift 0, 16, 32 or 48 is nonzero and every other lane is zero. The immediate is that lane and the shift is its bit offset.
- R5: Form code 5 (32-bit inverted move) is reported when bits [63:32] are zero and one of the two low lanes is 0xFFFF. The immediate is the bitwise complement of the other low lane, and the shift is 0 or 16.
- R6: Form code 6 (64-bit inverted move) is reported only in 64-bit mode, when every lane except one is 0xFFFF. The immediate is the complement of the remaining lane, and the shift is its offset (0, 16, 32 or 48).
- R7: When several forms fit, the order is add, 32-bit subtract, 64-bit subtract, zero-fill, 32-bit inverted, 64-bit inverted. Within a form, the smaller shift wins.
- R8: In 32-bit mode (wide input 0), any value with a nonzero bit in [63:32] yields no match. Form codes 3 and 6 are never reported in that mode.
- R9: When nothing fits, fit is 0, literal-required is 1, the form code is 0, and the immediate and shift are both 0.
- R10: All outputs change exactly one rising clock edge after the inputs are sampled. While reset is high, fit and literal-required are both 0.
- R11: Fit and literal-required are never both high, and exactly one of them is high on every cycle after the first post-reset edge.
- R12: For forms 1 to 3 the immediate is at most 4095 and the shift is 0 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| target_i | input | 64 | Constant to be synthesized |
| wide_i | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| fit_o | output | 1 | A single form produces the constant |
| literal_o | output | 1 | No form fits; a literal load is needed |
| form_o | output | 3 | Chosen form code (0 = none) |
| imm_o | output | 16 | Encoded immediate field |
| shamt_o | output | 6 | Left-shift amount in bits |

## Verification
Every output is due one rising edge after the target and width are applied, because a single register stage sits behind the combinational search. The bench changes the inputs 1 ns after a rising edge and compares all five outputs 1 ns after the following edge. Once, it also samples just before that edge, to confirm that the previous verdict still holds. Exhaustive sweeps cover every 12-bit immediate in each add and subtract placement in both modes. They are followed by lane-structured and pseudo-random values, all checked against an arithmetic model that rebuilds each candidate and compares it.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int XLEN        = 64;
  localparam int WLEN        = 32;
  localparam int LANE_W      = 16;
  localparam int NLANES      = XLEN / LANE_W;
  localparam int WLANES      = WLEN / LANE_W;
  localparam int SMALL_IMM_W = 12;
  localparam int IMM_W       = LANE_W;
  localparam int SHAMT_W     = $clog2(XLEN);
  localparam int NSLOT       = 6;

  typedef enum logic [2:0] {
    FORM_NONE  = 3'd0,
    FORM_ADD   = 3'd1,
    FORM_SUB_W = 3'd2,
    FORM_SUB_X = 3'd3,
    FORM_ZFILL = 3'd4,
    FORM_INV_W = 3'd5,
    FORM_INV_X = 3'd6
  } form_e;

  typedef struct packed {
    logic               hit;
    logic [IMM_W-1:0]   imm;
    logic [SHAMT_W-1:0] shamt;
  } cand_t;

  // Priority slot to form code; slot 0 is the most preferred.
  function automatic form_e slot_form(int slot);
    case (slot)
      0:       return FORM_ADD;
      1:       return FORM_SUB_W;
      2:       return FORM_SUB_X;
      3:       return FORM_ZFILL;
      4:       return FORM_INV_W;
      5:       return FORM_INV_X;
      default: return FORM_NONE;
    endcase
  endfunction

  // Value an instruction of the given form writes to a 64-bit register.
  function automatic logic [XLEN-1:0] rebuild(form_e f, logic [IMM_W-1:0] imm,
                                              logic [SHAMT_W-1:0] sh);
    logic [XLEN-1:0] placed;
    logic [XLEN-1:0] neg;
    placed = XLEN'(imm) << sh;
    neg    = '0 - placed;
    case (f)
      FORM_ADD, FORM_ZFILL: return placed;
      FORM_SUB_X:           return neg;
      FORM_SUB_W:           return {{(XLEN-WLEN){1'b0}}, neg[WLEN-1:0]};
      FORM_INV_X:           return ~placed;
      FORM_INV_W:           return {{(XLEN-WLEN){1'b0}}, ~placed[WLEN-1:0]};
      default:              return '0;
    endcase
  endfunction
endpackage

// File: rtl/csel_imm12_match.sv
// Matches value = +/-(k << s) modulo 2^REG_W, k a SMALL_IMM_W-bit field,
// s in {0, SMALL_IMM_W}. NEGATE selects the subtract-from-zero variant.
module csel_imm12_match
  import csel_pkg::*;
#(
  parameter int REG_W   = XLEN,
  parameter bit NEGATE  = 1'b0,
  parameter int FIELD_W = SMALL_IMM_W
) (
  input  logic [REG_W-1:0] opnd_i,
  output cand_t            cand_o
);
  localparam int HI_END = 2 * FIELD_W;

  logic [REG_W-1:0] mag;
  logic             low_ok;
  logic             high_ok;
  logic             nonzero_ok;

  always_comb begin
    mag        = NEGATE ? (~opnd_i + REG_W'(1)) : opnd_i;
    low_ok     = (mag >> FIELD_W) == '0;
    high_ok    = ((mag >> HI_END) == '0) && (mag[FIELD_W-1:0] == '0);
    // Zero itself belongs to the add form; a subtract of zero is never chosen.
    nonzero_ok = NEGATE ? (mag != '0) : 1'b1;
    cand_o     = '0;
    if (low_ok && nonzero_ok) begin
      cand_o.hit   = 1'b1;
      cand_o.imm   = IMM_W'(mag[FIELD_W-1:0]);
      cand_o.shamt = '0;
    end else if (high_ok && nonzero_ok) begin
      cand_o.hit   = 1'b1;
      cand_o.imm   = IMM_W'(mag[HI_END-1:FIELD_W]);
      cand_o.shamt = SHAMT_W'(FIELD_W);
    end
  end
endmodule

// File: rtl/csel_lane_match.sv
// Finds the lowest lane such that all other lanes equal the fill pattern.
module csel_lane_match
  import csel_pkg::*;
#(
  parameter int NL        = NLANES,
  parameter bit FILL_ONES = 1'b0
) (
  input  logic [NL*LANE_W-1:0] opnd_i,
  output cand_t                cand_o
);
  localparam logic [LANE_W-1:0] FILL = {LANE_W{FILL_ONES}};

  logic [NL-1:0] is_fill;
  logic [NL-1:0] others_ok;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign is_fill[g]   = opnd_i[g*LANE_W +: LANE_W] == FILL;
    assign others_ok[g] = &(is_fill | (NL'(1) << g));
  end

  always_comb begin
    cand_o = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (others_ok[i]) begin
        cand_o.hit   = 1'b1;
        cand_o.imm   = opnd_i[i*LANE_W +: LANE_W] ^ FILL;
        cand_o.shamt = SHAMT_W'(i * LANE_W);
      end
    end
  end
endmodule

// File: rtl/csel_prio.sv
// Fixed-priority pick among qualified candidates; slot 0 wins.
module csel_prio
  import csel_pkg::*;
#(
  parameter int NS = NSLOT
) (
  input  cand_t [NS-1:0] cands_i,
  input  logic  [NS-1:0] allow_i,
  output form_e          form_o,
  output cand_t          pick_o
);
  always_comb begin
    form_o = FORM_NONE;
    pick_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (cands_i[i].hit && allow_i[i]) begin
        form_o = slot_form(i);
        pick_o = cands_i[i];
      end
    end
  end
endmodule

// File: rtl/csel_const_selector.sv
module csel_const_selector
  import csel_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [XLEN-1:0]     target_i,
  input  logic                wide_i,
  output logic                fit_o,
  output logic                literal_o,
  output logic [2:0]          form_o,
  output logic [IMM_W-1:0]    imm_o,
  output logic [SHAMT_W-1:0]  shamt_o
);
  cand_t              add_c, subw_c, subx_c, zfill_c, invw_c, invx_c;
  cand_t [NSLOT-1:0]  cands;
  logic  [NSLOT-1:0]  allow;
  logic               upper_zero;
  logic               narrow_ok;
  form_e              pick_form;
  cand_t              pick;

  assign upper_zero = target_i[XLEN-1:WLEN] == '0;
  assign narrow_ok  = wide_i || upper_zero;

  csel_imm12_match #(.REG_W(XLEN), .NEGATE(1'b0)) u_add (
    .opnd_i(target_i), .cand_o(add_c));
  csel_imm12_match #(.REG_W(WLEN), .NEGATE(1'b1)) u_subw (
    .opnd_i(target_i[WLEN-1:0]), .cand_o(subw_c));
  csel_imm12_match #(.REG_W(XLEN), .NEGATE(1'b1)) u_subx (
    .opnd_i(target_i), .cand_o(subx_c));
  csel_lane_match #(.NL(NLANES), .FILL_ONES(1'b0)) u_zfill (
    .opnd_i(target_i), .cand_o(zfill_c));
  csel_lane_match #(.NL(WLANES), .FILL_ONES(1'b1)) u_invw (
    .opnd_i(target_i[WLEN-1:0]), .cand_o(invw_c));
  csel_lane_match #(.NL(NLANES), .FILL_ONES(1'b1)) u_invx (
    .opnd_i(target_i), .cand_o(invx_c));

  assign cands = {invx_c, invw_c, zfill_c, subx_c, subw_c, add_c};
  assign allow = {wide_i, upper_zero, narrow_ok, wide_i, upper_zero, narrow_ok};

  csel_prio #(.NS(NSLOT)) u_prio (
    .cands_i(cands), .allow_i(allow), .form_o(pick_form), .pick_o(pick));

  logic               fit_q, lit_q, primed_q;
  form_e              form_q;
  logic [IMM_W-1:0]   imm_q;
  logic [SHAMT_W-1:0] shamt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fit_q    <= 1'b0;
      lit_q    <= 1'b0;
      primed_q <= 1'b0;
      form_q   <= FORM_NONE;
      imm_q    <= '0;
      shamt_q  <= '0;
    end else begin
      fit_q    <= pick.hit;
      lit_q    <= !pick.hit;
      primed_q <= 1'b1;
      form_q   <= pick_form;
      imm_q    <= pick.imm;
      shamt_q  <= pick.shamt;
    end
  end

  assign fit_o     = fit_q;
  assign literal_o = lit_q;
  assign form_o    = form_q;
  assign imm_o     = imm_q;
  assign shamt_o   = shamt_q;

  // R11
  fit_lit_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (fit_o ^ literal_o));

  // R10
  rebuild_matches_chk: assert property (@(posedge clk) disable iff (rst)
    fit_o |-> rebuild(form_q, imm_o, shamt_o) == $past(target_i));

  // R8
  narrow_forms_chk: assert property (@(posedge clk) disable iff (rst)
    (fit_o && !$past(wide_i)) |->
      (form_q != FORM_SUB_X && form_q != FORM_INV_X && $past(target_i[XLEN-1:WLEN]) == '0));

  // R9
  literal_clean_chk: assert property (@(posedge clk) disable iff (rst)
    literal_o |-> (form_q == FORM_NONE && imm_o == '0 && shamt_o == '0));

  // R12
  small_imm_range_chk: assert property (@(posedge clk) disable iff (rst)
    (fit_o && (form_q == FORM_ADD || form_q == FORM_SUB_W || form_q == FORM_SUB_X)) |->
      (imm_o[IMM_W-1:SMALL_IMM_W] == '0 &&
       (shamt_o == '0 || shamt_o == SHAMT_W'(SMALL_IMM_W))));
endmodule

// File: tb/csel_const_selector_bench.sv
module csel_const_selector_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] target = '0;
  logic        wide = 1'b1;
  logic        fit, lit;
  logic [2:0]  form;
  logic [15:0] imm;
  logic [5:0]  shamt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic        e_fit;
  logic [2:0]  e_form;
  logic [15:0] e_imm;
  logic [5:0]  e_sh;

  always #5 clk = ~clk;

  csel_const_selector u_csel_const_selector (
    .clk(clk), .rst(rst), .target_i(target), .wide_i(wide),
    .fit_o(fit), .literal_o(lit), .form_o(form), .imm_o(imm), .shamt_o(shamt));

  // Arithmetic model: derive each candidate immediate, rebuild, compare.
  task automatic model(input logic [63:0] t, input bit w);
    logic [63:0] m, u, r;
    logic [15:0] k;
    e_fit = 1'b0; e_form = 3'd0; e_imm = '0; e_sh = '0;
    if (!w && t[63:32] != 0) return;
    for (int s = 0; s <= 12; s += 12) begin            // add
      k = 16'((t >> s) & 64'hFFF); r = 64'(k) << s;
      if (!e_fit && r == t) begin e_fit = 1; e_form = 3'd1; e_imm = k; e_sh = 6'(s); end
    end
    if (t[63:32] == 0) begin                          // 32-bit subtract
      m = {32'd0, 32'd0 - t[31:0]};
      for (int s = 0; s <= 12; s += 12) begin
        k = 16'((m >> s) & 64'hFFF); r = {32'd0, 32'(64'(k) << s)};
        if (!e_fit && k != 0 && r == m) begin e_fit = 1; e_form = 3'd2; e_imm = k; e_sh = 6'(s); end
      end
    end
    if (w) begin                                      // 64-bit subtract
      m = 64'd0 - t;
      for (int s = 0; s <= 12; s += 12) begin
        k = 16'((m >> s) & 64'hFFF); r = 64'(k) << s;
        if (!e_fit && k != 0 && r == m) begin e_fit = 1; e_form = 3'd3; e_imm = k; e_sh = 6'(s); end
      end
    end
    for (int s = 0; s < (w ? 64 : 32); s += 16) begin // zero-fill
      k = 16'(t >> s); r = 64'(k) << s;
      if (!e_fit && r == t) begin e_fit = 1; e_form = 3'd4; e_imm = k; e_sh = 6'(s); end
    end
    if (t[63:32] == 0) begin                          // 32-bit inverted
      u = {32'd0, ~t[31:0]};
      for (int s = 0; s < 32; s += 16) begin
        k = 16'(u >> s); r = 64'(k) << s;
        if (!e_fit && r == u) begin e_fit = 1; e_form = 3'd5; e_imm = k; e_sh = 6'(s); end
      end
    end
    if (w) begin                                      // 64-bit inverted
      u = ~t;
      for (int s = 0; s < 64; s += 16) begin
        k = 16'(u >> s); r = 64'(k) << s;
        if (!e_fit && r == u) begin e_fit = 1; e_form = 3'd6; e_imm = k; e_sh = 6'(s); end
      end
    end
  endtask

  function automatic string req_of(bit w, logic [63:0] t, logic [2:0] f);
    string s;
    case (f)
      3'd1: s = "R1 R12";
      3'd2: s = "R2 R12";
      3'd3: s = "R3 R12";
      3'd4: s = "R4";
      3'd5: s = "R5";
      3'd6: s = "R6";
      default: s = (!w && t[63:32] != 0) ? "R8 R9" : "R9";
    endcase
    return {s, " R7 R11"};
  endfunction

  task automatic compare(input logic [63:0] t, input bit w, input string tag);
    n_chk++;
    if (fit !== e_fit || lit !== !e_fit || form !== e_form || imm !== e_imm || shamt !== e_sh) begin
      n_bad++;
      $display("FAIL %s t=%h wide=%0d got fit=%0d lit=%0d form=%0d imm=%h sh=%0d exp fit=%0d lit=%0d form=%0d imm=%h sh=%0d",
               tag, t, w, fit, lit, form, imm, shamt, e_fit, !e_fit, e_form, e_imm, e_sh);
    end
  endtask

  // Inputs change 1 ns after a rising edge; the result is read 1 ns after the next.
  task automatic apply(input logic [63:0] t, input bit w);
    target = t; wide = w;
    model(t, w);
    @(posedge clk); #1;
    compare(t, w, req_of(w, t, e_form));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [63:0] lf;
    logic [15:0] lv;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    n_chk++;
    if (fit !== 1'b0 || lit !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset fit=%0d lit=%0d exp 0 0", fit, lit);
    end
    rst = 1'b0;

    // R10: outputs hold until the next edge, then update
    apply(64'h1234, 1'b1);
    target = 64'h0000_0000_0000_0FFF;
    #3;
    n_chk++;
    if (form !== 3'd4 || imm !== 16'h1234) begin
      n_bad++;
      $display("FAIL R10 early change form=%0d imm=%h exp 4 1234", form, imm);
    end
    @(posedge clk); #1;
    model(64'hFFF, 1'b1);
    compare(64'hFFF, 1'b1, "R10 R1");

    // R1 R2 R3 R12: every 12-bit immediate in each placement, both modes
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 4096; k++) begin
        apply(64'(k), w[0]);
        apply(64'(k) << 12, w[0]);
        apply({32'd0, 32'd0 - 32'(k)}, w[0]);
        apply({32'd0, 32'd0 - (32'(k) << 12)}, w[0]);
        apply(64'd0 - 64'(k), w[0]);
        apply(64'd0 - (64'(k) << 12), w[0]);
      end
    end

    // R4 R5 R6 R7: one lane differing from an all-zero or all-one fill
    lv = 16'h1;
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 2; f++)
        for (int ln = 0; ln < 4; ln++)
          for (int v = 0; v < 48; v++) begin
            case (v)
              0: lv = 16'h0000; 1: lv = 16'hFFFF; 2: lv = 16'h0FFF; 3: lv = 16'hF000;
              4: lv = 16'h8000; 5: lv = 16'h0001; 6: lv = 16'hFFFE; 7: lv = 16'h1000;
              default: lv = {lv[14:0], lv[15] ^ lv[13] ^ lv[12] ^ lv[10]} ^ 16'(v * 37);
            endcase
            lf = f ? '1 : '0;
            lf[ln*16 +: 16] = lv;
            apply(lf, w[0]);
            apply({32'd0, lf[31:0]}, w[0]);
          end

    // R8 R9: pseudo-random values, including upper bits in 32-bit mode
    lf = 64'hACE1_2468_1357_9BDF;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      apply(lf, i[0]);
      apply(lf & 64'h0000_0001_0000_FFFF, i[1]);
      apply(lf | 64'hFFFF_FFFF_0000_FFFF, i[1]);
    end

    done = 1'b1;
    summary();
  end
endmodule